// File: doc/BRIEF.md
# Low-Power Dual-Channel PWM Timer

A register-programmed timer that produces up to two pulse-width-modulated outputs from one counter. A power-of-two prescaler divides the input clock by 1 to 128; the counter then runs from zero up to a programmed reload value and wraps. Each channel compares the counter with its own compare value. The output is active while the counter is above that value, and a per-channel polarity bit inverts it.

Software programs the block through a small write-strobe register bus with a combinational read path. Some registers only accept writes in particular states. The configuration register (prescaler exponent, legacy polarity) is frozen while the timer is enabled. Reload and compare registers accept writes only while it is enabled. New reload and compare values are held as pending values and take effect at the next counter wrap, or one cycle later if the counter has not been started. A sticky completion flag per register reports the load, and software clears it by writing a one.

A build parameter selects a single-output variant. In that variant the channel-mode register does not exist and one polarity bit in the configuration register inverts the only output.

Top module: `lptmr_pwm`

## Requirements
- R1: After reset all outputs are low, STATUS (address 6) reads 0 and the counter is stopped.
- R2: CFG (address 1) bits [2:0] hold exponent e; the counter advances once every 2^e clocks, runs 0..RELOAD (address 3) and wraps, so the output period is (RELOAD+1)·2^e clocks.
- R3: A channel is active while counter > its compare value (CMP0 address 4, CMP1 address 5), giving RELOAD−CMP counts of active time per period.
- R4: Writes to CFG are ignored while the timer enable (CTRL bit 0) is 1.
- R5: Writes to RELOAD, CMP0 and CMP1 are ignored while the timer enable is 0.
- R6: A written RELOAD or CMP value loads at the next counter wrap, or one cycle after the write while the counter is not started. The load sets the STATUS flag: bit 0 for reload, bit 1 for CMP0, bit 2 for CMP1.
- R7: Writing 1 to a bit of CLEAR (address 7) clears the matching STATUS bit and leaves the other bits set.
- R8: CHMODE (address 2) bit 2i enables channel i and bit 2i+1 sets its polarity. A channel is driven only when the timer enable and its own enable are both 1; otherwise its output sits at its polarity level.
- R9: A polarity bit written while that channel's enable is 1 is ignored.
- R10: After an accepted CHMODE write, further CHMODE writes are ignored for 3·2^e clock cycles.
- R11: In the single-output variant, CFG bit 3 inverts the only output, CMP0 drives it, and CHMODE reads 0.
- R12: CTRL bit 1 starts the counter only if the timer enable was already 1 before the write. Writing CTRL bit 0 = 0 stops the counter and returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe, one register write per cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pwm_out | output | 2 | Channel outputs, one bit per channel |

## Verification
The hardest state to reach from the ports is a compare write made while the counter is running, with enough cycles left before the wrap to see that the completion flag stays clear. The bench watches the channel output until its active edge, at which point the counter position is known. It writes the new compare value in the following cycle and reads STATUS before and after the expected wrap. The channel-mode lockout is reached in a similar way: back-to-back writes go out in the cycles straight after an accepted write, before the lockout window has run out.

// File: rtl/lptmr_pkg.sv
`timescale 1ns/1ps
package lptmr_pkg;
  localparam int ADDR_W = 3;
  localparam int EXP_W  = 3;
  localparam int PRE_W  = 1 << EXP_W;
  localparam int LOCK_W = EXP_W + 3;
  localparam int LOCK_WB = PRE_W + 2;

  typedef enum logic [ADDR_W-1:0] {
    RG_CTRL   = 3'd0,
    RG_CFG    = 3'd1,
    RG_CHMODE = 3'd2,
    RG_RELOAD = 3'd3,
    RG_CMP0   = 3'd4,
    RG_CMP1   = 3'd5,
    RG_STATUS = 3'd6,
    RG_CLEAR  = 3'd7
  } reg_sel_e;

  // last prescaler count before a tick: 2^e - 1
  function automatic logic [PRE_W-1:0] div_last(input logic [EXP_W-1:0] e);
    div_last = (PRE_W'(1) << e) - PRE_W'(1);
  endfunction

  // channel-mode lockout length: 3 * 2^e clock cycles
  function automatic logic [LOCK_WB-1:0] lock_cycles(input logic [EXP_W-1:0] e);
    lock_cycles = LOCK_WB'(3) << e;
  endfunction

  // pin level from the active state and the polarity bit
  function automatic logic drive_level(input logic on, input logic pol);
    drive_level = on ^ pol;
  endfunction
endpackage

// File: rtl/lptmr_prescaler.sv
`timescale 1ns/1ps
module lptmr_prescaler
  import lptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;

  assign tick = run && (pcnt == div_last(exp_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pcnt <= '0;
    else if (!run || tick)  pcnt <= '0;
    else                    pcnt <= pcnt + PRE_W'(1);
  end

  // R2: prescaler count never passes the divide boundary
  p_presc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= div_last(exp_sel) || !run || $changed(exp_sel));
endmodule

// File: rtl/lptmr_counter.sv
`timescale 1ns/1ps
module lptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = tick && (cnt == reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (tick)   cnt <= cnt + CNT_W'(1);
  end

  // R2: while counting the counter stays within 0..reload
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= reload);
  // R2: a wrap returns the counter to zero
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  // R12: a stopped counter sits at zero
  p_stop_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/lptmr_shadow.sv
`timescale 1ns/1ps
module lptmr_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         timer_on,
  input  logic         counting,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         wrap,
  input  logic         clr,
  output logic [W-1:0] act,
  output logic         ok
);
  logic [W-1:0] pend_val;
  logic         pend;
  logic         load;

  assign load = timer_on && pend && (wrap || !counting);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_val <= '0;
      pend     <= 1'b0;
      act      <= '0;
      ok       <= 1'b0;
    end else begin
      if (!timer_on) begin
        pend <= 1'b0;
      end else begin
        if (load) begin
          act  <= pend_val;
          pend <= 1'b0;
        end
        if (wr) begin
          pend_val <= wdata;
          pend     <= 1'b1;
        end
      end
      if (clr)  ok <= 1'b0;
      if (load) ok <= 1'b1;
    end
  end

  // R6: a load raises the completion flag
  p_load_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ok);
  // R6: the loaded value is the pending one
  p_load_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> act == $past(pend_val));
  // R6: the active value changes only on a load
  p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act));
endmodule

// File: rtl/lptmr_chan.sv
`timescale 1ns/1ps
module lptmr_chan
  import lptmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             timer_on,
  input  logic             ch_on,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             pwm
);
  logic drive;
  assign drive = timer_on && ch_on && (cnt > cmp);
  assign pwm   = drive_level(drive, pol);
endmodule

// File: rtl/lptmr_pwm.sv
`timescale 1ns/1ps
module lptmr_pwm
  import lptmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam bit LEGACY = (NUM_CH == 1);
  localparam int CHM_W  = 2 * NUM_CH;

  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  logic wr_ctrl, wr_cfg, wr_chm, wr_reload, wr_clear;
  assign wr_ctrl   = bus_we && (sel == RG_CTRL);
  assign wr_cfg    = bus_we && (sel == RG_CFG);
  assign wr_chm    = bus_we && (sel == RG_CHMODE);
  assign wr_reload = bus_we && (sel == RG_RELOAD);
  assign wr_clear  = bus_we && (sel == RG_CLEAR);

  // ---------------- control ----------------
  logic run_en, counting;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      counting <= 1'b0;
    end else if (wr_ctrl) begin
      run_en <= bus_wdata[0];
      if (!bus_wdata[0])                   counting <= 1'b0;
      else if (run_en && bus_wdata[1])     counting <= 1'b1;
    end
  end

  // ---------------- configuration ----------------
  logic [EXP_W-1:0] cfg_exp;
  logic             cfg_pol;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_exp <= '0;
      cfg_pol <= 1'b0;
    end else if (wr_cfg && !run_en) begin
      cfg_exp <= bus_wdata[EXP_W-1:0];
      cfg_pol <= LEGACY ? bus_wdata[EXP_W] : 1'b0;
    end
  end

  // ---------------- channel mode ----------------
  logic [NUM_CH-1:0] eff_en, eff_pol;
  logic [CHM_W-1:0]  chm_rd;

  generate
    if (LEGACY) begin : g_legacy
      assign eff_en  = '1;
      assign eff_pol = {NUM_CH{cfg_pol}};
      assign chm_rd  = '0;
    end else begin : g_multi
      logic [NUM_CH-1:0]  ch_en, ch_pol;
      logic [LOCK_WB-1:0] lock_cnt;
      logic               chm_ok;

      assign chm_ok = wr_chm && (lock_cnt == '0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ch_en  <= '0;
          ch_pol <= '0;
        end else if (chm_ok) begin
          for (int i = 0; i < NUM_CH; i++) begin
            ch_en[i] <= bus_wdata[2*i];
            if (!ch_en[i]) ch_pol[i] <= bus_wdata[2*i+1];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 lock_cnt <= '0;
        else if (chm_ok)            lock_cnt <= lock_cycles(cfg_exp);
        else if (lock_cnt != '0)    lock_cnt <= lock_cnt - LOCK_WB'(1);
      end

      always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
          chm_rd[2*i]   = ch_en[i];
          chm_rd[2*i+1] = ch_pol[i];
        end
      end

      assign eff_en  = ch_en;
      assign eff_pol = ch_pol;

      // R9: polarity of an enabled channel does not move
      p_pol_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_pol ^ $past(ch_pol)) & $past(ch_en)) == '0);
      // R10: writes inside the lockout window leave the mode unchanged
      p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_chm && lock_cnt != '0) |=> ($stable(ch_en) && $stable(ch_pol)));
    end
  endgenerate

  // ---------------- time base ----------------
  logic             tick, wrap;
  logic [CNT_W-1:0] cnt, reload_act;
  logic             reload_ok;

  lptmr_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .run(counting), .exp_sel(cfg_exp), .tick(tick)
  );

  lptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(counting), .tick(tick),
    .reload(reload_act), .cnt(cnt), .wrap(wrap)
  );

  lptmr_shadow #(.W(CNT_W)) u_reload (
    .clk(clk), .rst_n(rst_n), .timer_on(run_en), .counting(counting),
    .wr(wr_reload && run_en), .wdata(bus_wdata), .wrap(wrap),
    .clr(wr_clear && bus_wdata[0]), .act(reload_act), .ok(reload_ok)
  );

  // ---------------- channels ----------------
  logic [CNT_W-1:0]  cmp_act [NUM_CH];
  logic [NUM_CH-1:0] cmp_ok;
  logic [CNT_W-1:0]  cmp_rd [2];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic cmp_wr;
    assign cmp_wr = bus_we && run_en && (int'(bus_addr) == int'(RG_CMP0) + i);

    lptmr_shadow #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .timer_on(run_en), .counting(counting),
      .wr(cmp_wr), .wdata(bus_wdata), .wrap(wrap),
      .clr(wr_clear && bus_wdata[1+i]), .act(cmp_act[i]), .ok(cmp_ok[i])
    );

    lptmr_chan #(.CNT_W(CNT_W)) u_chan (
      .timer_on(run_en), .ch_on(eff_en[i]), .pol(eff_pol[i]),
      .cnt(cnt), .cmp(cmp_act[i]), .pwm(pwm_out[i])
    );
  end

  for (genvar i = 0; i < 2; i++) begin : g_cmp_rd
    if (i < NUM_CH) begin : g_has
      assign cmp_rd[i] = cmp_act[i];
    end else begin : g_none
      assign cmp_rd[i] = '0;
    end
  end

  // ---------------- read path ----------------
  always_comb begin
    bus_rdata = '0;
    case (sel)
      RG_CTRL:   bus_rdata = CNT_W'({counting, run_en});
      RG_CFG:    bus_rdata = CNT_W'({cfg_pol, cfg_exp});
      RG_CHMODE: bus_rdata = CNT_W'(chm_rd);
      RG_RELOAD: bus_rdata = reload_act;
      RG_CMP0:   bus_rdata = cmp_rd[0];
      RG_CMP1:   bus_rdata = cmp_rd[1];
      RG_STATUS: bus_rdata = CNT_W'({cmp_ok, reload_ok});
      default:   bus_rdata = '0;
    endcase
  end

  // R4: configuration frozen while enabled
  p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ($stable(cfg_exp) && $stable(cfg_pol)));
  // R5: reload value untouched while disabled
  p_reload_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(reload_act));
  // R8: disabled timer holds every output at its polarity level
  p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> pwm_out == eff_pol);
  // R12: counting only starts from an already enabled timer
  p_start_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(counting) |-> $past(run_en));
endmodule

// File: tb/lptmr_pwm_test.sv
`timescale 1ns/1ps
module lptmr_pwm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        we0 = 0, we1 = 0;
  logic [2:0]  addr0 = 0, addr1 = 0;
  logic [15:0] wd0 = 0, wd1 = 0;
  logic [15:0] rd0, rd1;
  logic [1:0]  pwm0;
  logic [0:0]  pwm1;

  lptmr_pwm #(.CNT_W(16), .NUM_CH(2)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(we0), .bus_addr(addr0),
    .bus_wdata(wd0), .bus_rdata(rd0), .pwm_out(pwm0));

  lptmr_pwm #(.CNT_W(16), .NUM_CH(1)) uut1 (
    .clk(clk), .rst_n(rst_n), .bus_we(we1), .bus_addr(addr1),
    .bus_wdata(wd1), .bus_rdata(rd1), .pwm_out(pwm1));

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    int    inst;
    int    ch;
    bit    pol;
    int    hi;
    int    per;
    string tag;
  } exp_t;
  exp_t sb_q[$];
  int pushed_n = 0, mon_done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bwr(input int which, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    if (which == 0) begin we0 = 1; addr0 = a; wd0 = d; end
    else            begin we1 = 1; addr1 = a; wd1 = d; end
    @(negedge clk);
    we0 = 0; we1 = 0;
  endtask

  task automatic brd(input int which, input logic [2:0] a, output int v);
    @(negedge clk);
    if (which == 0) begin addr0 = a; #1 v = int'(rd0); end
    else            begin addr1 = a; #1 v = int'(rd1); end
  endtask

  task automatic hold_check(input string tag, input int which, input int exp, input int cyc);
    int bad = -1;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (which == 0 && int'(pwm0) != exp && bad < 0) bad = int'(pwm0);
      if (which == 1 && int'(pwm1) != exp && bad < 0) bad = int'(pwm1);
    end
    chk(tag, (bad < 0) ? exp : bad, exp);
  endtask

  // driver side of the scoreboard
  task automatic expect_wave(input int inst, input int ch, input bit pol,
                             input int hi, input int per, input string tag);
    exp_t it;
    it.inst = inst; it.ch = ch; it.pol = pol; it.hi = hi; it.per = per; it.tag = tag;
    sb_q.push_back(it);
    pushed_n++;
    wait (mon_done == pushed_n);
  endtask

  function automatic bit act_of(input exp_t it);
    logic p;
    p = (it.inst == 0) ? pwm0[it.ch] : pwm1[0];
    return p ^ it.pol;
  endfunction

  // monitor side: measure one full active pulse and its period
  initial begin
    forever begin
      exp_t it;
      int hi, lo;
      wait (pushed_n > mon_done);
      it = sb_q[0];
      do @(negedge clk); while (act_of(it));
      do @(negedge clk); while (!act_of(it));
      do @(negedge clk); while (act_of(it));
      do @(negedge clk); while (!act_of(it));
      hi = 1; lo = 0;
      forever begin @(negedge clk); if (act_of(it)) hi++; else break; end
      lo = 1;
      forever begin @(negedge clk); if (!act_of(it)) lo++; else break; end
      void'(sb_q.pop_front());
      chk({it.tag, " active cycles"}, hi, it.hi);
      chk({it.tag, " period cycles"}, hi + lo, it.per);
      mon_done++;
    end
  end

  initial begin
    #(500000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 outputs after reset", int'(pwm0), 0);
    brd(0, 3'd6, v); chk("R1 status after reset", v, 0);
    brd(0, 3'd0, v); chk("R1 ctrl after reset", v, 0);

    // R5 reload write while disabled is ignored
    bwr(0, 3'd3, 16'd77);
    repeat (2) @(negedge clk);
    brd(0, 3'd3, v); chk("R5 reload ignored while off", v, 0);
    brd(0, 3'd6, v); chk("R5 no flag while off", v, 0);

    // R4 configuration frozen while enabled
    bwr(0, 3'd1, 16'd1);
    bwr(0, 3'd0, 16'd1);
    bwr(0, 3'd1, 16'd3);
    brd(0, 3'd1, v); chk("R4 cfg ignored while on", v, 1);

    // R6 stopped counter: load one cycle after write
    bwr(0, 3'd3, 16'd9);
    bwr(0, 3'd4, 16'd6);
    brd(0, 3'd6, v); chk("R6 flags after stopped load", v, 3);
    brd(0, 3'd3, v); chk("R6 reload value", v, 9);

    // R7 selective flag clear
    bwr(0, 3'd7, 16'd1);
    brd(0, 3'd6, v); chk("R7 clear bit 0 only", v, 2);
    bwr(0, 3'd7, 16'd2);
    brd(0, 3'd6, v); chk("R7 clear bit 1", v, 0);

    // R8 ch0 enabled, normal polarity; start R12
    bwr(0, 3'd2, 16'h1);
    bwr(0, 3'd0, 16'd3);
    brd(0, 3'd0, v); chk("R12 ctrl running", v, 3);
    expect_wave(0, 0, 0, 6, 20, "R2 R3 ch0 duty 3 e=1");

    // ch1 compare, then R10 lockout
    bwr(0, 3'd5, 16'd3);
    repeat (30) @(negedge clk);
    brd(0, 3'd6, v); chk("R6 cmp1 flag", v, 4);
    bwr(0, 3'd7, 16'd4);
    bwr(0, 3'd2, 16'hD);
    bwr(0, 3'd2, 16'h0);
    brd(0, 3'd2, v); chk("R10 write inside lockout ignored", v, 'hD);
    repeat (10) @(negedge clk);
    bwr(0, 3'd2, 16'hF);
    brd(0, 3'd2, v); chk("R9 polarity of enabled ch0 kept", v, 'hD);
    expect_wave(0, 1, 1, 12, 20, "R8 ch1 inverted duty 6");

    // R6 running: compare loads at wrap, not at write
    do @(negedge clk); while (pwm0[0]);
    do @(negedge clk); while (!pwm0[0]);
    bwr(0, 3'd4, 16'd1);
    brd(0, 3'd6, v); chk("R6 cmp0 flag deferred to wrap", v, 0);
    repeat (12) @(negedge clk);
    brd(0, 3'd6, v); chk("R6 cmp0 flag after wrap", v, 2);
    bwr(0, 3'd7, 16'd7);
    expect_wave(0, 0, 0, 16, 20, "R6 ch0 new duty 8");

    // R8 disabling ch0 parks it while ch1 keeps running
    repeat (10) @(negedge clk);
    bwr(0, 3'd2, 16'hC);
    hold_check("R8 ch0 off stays low", 0, 0, 1);
    begin
      int bad = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (pwm0[0] != 1'b0) bad = 1;
      end
      chk("R8 ch0 disabled output", bad, 0);
    end

    // R12 stop, start gated by prior enable, R8 idle levels
    bwr(0, 3'd0, 16'd0);
    hold_check("R8 idle level with timer off", 0, 2, 10);
    bwr(0, 3'd0, 16'd2);
    brd(0, 3'd0, v); chk("R12 start ignored while off", v, 0);
    bwr(0, 3'd1, 16'd0);
    bwr(0, 3'd0, 16'd1);
    hold_check("R12 enabled not started holds inactive", 0, 2, 30);
    bwr(0, 3'd0, 16'd3);
    expect_wave(0, 1, 1, 6, 10, "R2 R12 ch1 restart e=0");

    // R11 single-output variant
    brd(1, 3'd2, v); chk("R11 chmode reads 0", v, 0);
    bwr(1, 3'd1, 16'h8);
    hold_check("R11 inverted idle level", 1, 1, 3);
    bwr(1, 3'd0, 16'd1);
    bwr(1, 3'd3, 16'd4);
    bwr(1, 3'd4, 16'd2);
    bwr(1, 3'd0, 16'd3);
    expect_wave(1, 0, 1, 2, 5, "R11 single output duty 2");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule